// File: doc/BRIEF.md
# Paced Parallel Output Engine

This engine moves data words from an internal output FIFO onto a parallel data bus. The FIFO is filled through a simple write port. Once a run is started with a `go` pulse, a start gate holds the first word back until the selected condition is met. The engine then releases words in one of four ways:

- under an internal pace with a one-cycle strobe on `req`;
- through a request/acknowledge handshake;
- as a burst that is paced by a selected rate and qualified by `ack`;
- as a repeating pattern that replays the FIFO contents without consuming them.

The engine reports FIFO empty and full. It also keeps a sticky underrun flag, which is set whenever a word falls due and the FIFO has nothing to give. The sample width can be set to 8, 16 or the full bus width, and the unused upper lines are driven low. A run ends with a `stop` pulse. In pattern mode a run can also end when the trigger is released, if that option is enabled.

Top module: `paced_out_engine`

## Requirements
- R1: While reset is held, `dout` is 0, `req` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `underrun` is 0.
- R2: After `go`, the start gate selected by `cfg_gate` must open before the run begins. Code 0 opens at once. Code 1 waits for `trig`=1. Code 2 waits for FIFO occupancy to exceed `cfg_ae_level`. Code 3 waits for both conditions together. The run starts on the cycle after the gate opens.
- R3: With `cfg_mode`=0 (paced), one word is popped at each pace tick and `req` pulses for the single cycle in which that word first appears on `dout`. The pace tick depends on `cfg_rate`: code 0 ticks every cycle, code 1 ticks every second running cycle starting with the second one, and codes 2 and 3 follow `timer_tick`.
- R4: With `cfg_mode`=1 (handshake), `req` rises together with a new word only in a cycle following one where `ack` was 0. After rising, `req` stays high until `ack` has been seen at 1, and then falls.
- R5: With `cfg_mode`=2 (burst), `req` is held at 1 for the whole run. A word is popped on each pace tick, selected by `cfg_rate` as in R3, in which `ack` is 1.
- R6: When a word falls due in mode 0, 1 or 2 and the FIFO is empty, `underrun` is set to 1 and nothing is popped. `underrun` stays at 1 until the next accepted `go`.
- R7: With `cfg_mode`=3 (pattern), each pace tick drives the next stored word and returns to the oldest word after the newest. FIFO occupancy does not change, and `underrun` is never set.
- R8: In pattern mode with `cfg_trig_stop`=1, the run ends in the first cycle in which `trig` is 0. No further word or strobe is driven.
- R9: `cfg_width` code 0 drives only `dout[7:0]` and code 1 drives only `dout[15:0]`, with the upper bits 0. Codes 2 and 3 drive the whole bus.
- R10: While the start gate is pending, `dout` keeps its last driven value and `req` stays 0.
- R11: A `stop` pulse ends the run or the wait at the next edge, regardless of any other event in that cycle, and `req` then returns to 0.
- R12: `fifo_full` is 1 when `DEPTH` words are stored and `fifo_empty` is 1 when none are. A write while the FIFO is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | DATA_W | FIFO write data |
| cfg_mode | input | 2 | Transfer mode: 0 paced, 1 handshake, 2 burst, 3 pattern |
| cfg_gate | input | 2 | Start gate: 0 now, 1 trigger, 2 level, 3 both |
| cfg_width | input | 2 | Sample width: 0 8-bit, 1 16-bit, 2/3 full |
| cfg_rate | input | 2 | Pace source: 0 every cycle, 1 half rate, 2/3 timer |
| cfg_trig_stop | input | 1 | End a pattern run when the trigger drops |
| cfg_ae_level | input | CW | Almost-empty level for the level gate |
| go | input | 1 | Start pulse, accepted only when idle |
| stop | input | 1 | Stop pulse |
| trig | input | 1 | External trigger, active high |
| ack | input | 1 | Acknowledge from the receiver |
| timer_tick | input | 1 | Timer pace pulse |
| dout | output | DATA_W | Parallel output data |
| req | output | 1 | Request or strobe to the receiver |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Two things can fall in the same cycle: a host write into the FIFO, and a drain event that pops a word or finds the FIFO empty. This is provoked in two ways. First, the FIFO is filled while a level-gated paced run is already draining it. Second, the FIFO is topped up exactly as a handshake or burst run runs dry. The behavioural queue model judges occupancy before the write: a pop and a push in one cycle leave the count unchanged, and a write landing in the cycle an empty FIFO is due does not prevent the underrun. The model also judges `stop` against a pending tick and the gate opening against the cycle of arrival.

// File: rtl/po_pkg.sv
package po_pkg;

  typedef enum logic [1:0] {
    M_PACE    = 2'd0,
    M_HSHK    = 2'd1,
    M_BURST   = 2'd2,
    M_PATTERN = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARMED = 2'd1,
    S_RUN   = 2'd2
  } phase_e;

  // Start gate decision from the selector and the two conditions.
  function automatic logic gate_open(input logic [1:0] sel,
                                     input logic trig_ok,
                                     input logic lvl_ok);
    case (sel)
      2'd0:    return 1'b1;
      2'd1:    return trig_ok;
      2'd2:    return lvl_ok;
      default: return trig_ok && lvl_ok;
    endcase
  endfunction

  // Number of live data lanes for a width code.
  function automatic int lane_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/po_pacer.sv
module po_pacer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate_sel,
  input  logic       timer_tick,
  output logic       tick
);

  logic half_ph;

  // Half-rate phase restarts with every run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_ph <= 1'b0;
    else        half_ph <= run ? ~half_ph : 1'b0;
  end

  always_comb begin
    case (rate_sel)
      2'd0:    tick = 1'b1;
      2'd1:    tick = half_ph;
      default: tick = timer_tick;
    endcase
  end

endmodule

// File: rtl/po_fifo.sv
module po_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  input  logic              pat_step,
  input  logic              pat_rst,
  output logic [DATA_W-1:0] head_data,
  output logic [DATA_W-1:0] pat_data,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr, pat_ptr;
  logic              push;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign push      = wr_en && !full;
  assign head_data = mem[rd_ptr];
  assign pat_data  = mem[pat_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      pat_ptr <= '0;
      count   <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
      // Pattern pointer walks oldest..newest and wraps to the oldest.
      if (pat_rst)
        pat_ptr <= rd_ptr;
      else if (pat_step)
        pat_ptr <= (step_ptr(pat_ptr) == wr_ptr) ? rd_ptr : step_ptr(pat_ptr);
    end
  end

  // R6: the sequencer never drains an empty FIFO.
  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/po_seq.sv
module po_seq
  import po_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_gate,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_trig_stop,
  input  logic [CW-1:0]     cfg_ae_level,
  input  logic              go,
  input  logic              stop,
  input  logic              trig,
  input  logic              ack,
  input  logic              tick,
  input  logic [CW-1:0]     count,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  input  logic [DATA_W-1:0] pat_data,
  output logic              pop,
  output logic              pat_step,
  output logic              pat_rst,
  output logic              running,
  output logic [DATA_W-1:0] dout_q,
  output logic              req_q,
  output logic              underrun_q
);

  mode_e  mode;
  phase_e st, st_n;
  logic   hs, hs_n;
  logic   lvl_ok, go_clr, halt_trig, under_evt, req_n;

  function automatic logic [DATA_W-1:0] fit_width(input logic [DATA_W-1:0] w,
                                                  input logic [1:0] code);
    logic [DATA_W-1:0] r;
    int keep;
    keep = lane_bits(code);
    for (int i = 0; i < DATA_W; i++) r[i] = (i < keep) ? w[i] : 1'b0;
    return r;
  endfunction

  assign mode      = mode_e'(cfg_mode);
  assign lvl_ok    = (count > cfg_ae_level);
  assign go_clr    = (st == S_IDLE) && go && !stop;
  assign halt_trig = (mode == M_PATTERN) && cfg_trig_stop && !trig;
  assign running   = (st == S_RUN);
  assign pat_rst   = (st != S_RUN);

  always_comb begin
    st_n      = st;
    hs_n      = hs;
    pop       = 1'b0;
    pat_step  = 1'b0;
    under_evt = 1'b0;
    if (stop) begin
      st_n = S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (go) st_n = S_ARMED;
        S_ARMED: if (gate_open(cfg_gate, trig, lvl_ok)) st_n = S_RUN;
        S_RUN: begin
          if (halt_trig) begin
            st_n = S_IDLE;
          end else begin
            case (mode)
              M_PACE: if (tick) begin
                if (empty) under_evt = 1'b1;
                else       pop       = 1'b1;
              end
              M_HSHK: begin
                if (!hs && !ack) begin
                  if (empty) under_evt = 1'b1;
                  else begin
                    pop  = 1'b1;
                    hs_n = 1'b1;
                  end
                end else if (hs && ack) begin
                  hs_n = 1'b0;
                end
              end
              M_BURST: if (tick && ack) begin
                if (empty) under_evt = 1'b1;
                else       pop       = 1'b1;
              end
              default: if (tick && !empty) pat_step = 1'b1;
            endcase
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
    if (st_n != S_RUN) hs_n = 1'b0;
  end

  always_comb begin
    case (mode)
      M_HSHK:  req_n = hs_n;
      M_BURST: req_n = (st_n == S_RUN);
      default: req_n = pop || pat_step;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      hs         <= 1'b0;
      dout_q     <= '0;
      req_q      <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      st    <= st_n;
      hs    <= hs_n;
      req_q <= req_n;
      if (pop)           dout_q <= fit_width(head_data, cfg_width);
      else if (pat_step) dout_q <= fit_width(pat_data, cfg_width);
      if (go_clr)         underrun_q <= 1'b0;
      else if (under_evt) underrun_q <= 1'b1;
    end
  end

  // R4: request rises only after acknowledge was low.
  p_hs_raise_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HSHK && $rose(req_q)) |-> !$past(ack));

  // R4: while running, request drops only after acknowledge was seen.
  p_hs_drop_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HSHK && $fell(req_q) && st == S_RUN) |-> $past(ack));

  // R6: the underrun flag holds until a new run is accepted.
  p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(underrun_q) && !$past(go_clr)) |-> underrun_q);

  // R10: data bus frozen while the gate is pending.
  p_hold_while_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED) |=> $stable(dout_q));

endmodule

// File: rtl/paced_out_engine.sv
module paced_out_engine #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_gate,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_trig_stop,
  input  logic [CW-1:0]     cfg_ae_level,
  input  logic              go,
  input  logic              stop,
  input  logic              trig,
  input  logic              ack,
  input  logic              timer_tick,
  output logic [DATA_W-1:0] dout,
  output logic              req,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              underrun
);

  logic [DATA_W-1:0] head_data, pat_data;
  logic [CW-1:0]     count;
  logic              pop, pat_step, pat_rst, running, tick;

  po_pacer u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (running),
    .rate_sel   (cfg_rate),
    .timer_tick (timer_tick),
    .tick       (tick)
  );

  po_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pop       (pop),
    .pat_step  (pat_step),
    .pat_rst   (pat_rst),
    .head_data (head_data),
    .pat_data  (pat_data),
    .count     (count),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  po_seq #(.DATA_W(DATA_W), .CW(CW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_gate      (cfg_gate),
    .cfg_width     (cfg_width),
    .cfg_trig_stop (cfg_trig_stop),
    .cfg_ae_level  (cfg_ae_level),
    .go            (go),
    .stop          (stop),
    .trig          (trig),
    .ack           (ack),
    .tick          (tick),
    .count         (count),
    .empty         (fifo_empty),
    .head_data     (head_data),
    .pat_data      (pat_data),
    .pop           (pop),
    .pat_step      (pat_step),
    .pat_rst       (pat_rst),
    .running       (running),
    .dout_q        (dout),
    .req_q         (req),
    .underrun_q    (underrun)
  );

  // R7: a pattern run leaves occupancy untouched when nothing is written.
  p_pattern_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cfg_mode == 2'd3 && !wr_en) |=> $stable(count));

endmodule

// File: tb/paced_out_engine_bench.sv
module paced_out_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 32;
  localparam int DEP = 8;
  localparam int CW  = $clog2(DEP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    cfg_mode = 2'd0, cfg_gate = 2'd0, cfg_width = 2'd2, cfg_rate = 2'd0;
  logic          cfg_trig_stop = 1'b0;
  logic [CW-1:0] cfg_ae_level = '0;
  logic          go = 1'b0, stop = 1'b0, trig = 1'b0, ack = 1'b0, timer_tick = 1'b0;
  logic [DW-1:0] dout;
  logic          req, fifo_empty, fifo_full, underrun;

  int    n_checks = 0;
  int    n_err = 0;
  int    cycles = 0;
  bit    hs_auto = 0;
  string cur_req = "R1";

  paced_out_engine #(.DATA_W(DW), .DEPTH(DEP)) u_paced_out_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_mode(cfg_mode), .cfg_gate(cfg_gate), .cfg_width(cfg_width),
    .cfg_rate(cfg_rate), .cfg_trig_stop(cfg_trig_stop), .cfg_ae_level(cfg_ae_level),
    .go(go), .stop(stop), .trig(trig), .ack(ack), .timer_tick(timer_tick),
    .dout(dout), .req(req), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int            m_st = 0;          // 0 idle, 1 waiting, 2 running
  logic [DW-1:0] m_q[$];
  logic [DW-1:0] m_dout = '0;
  bit            m_req = 0, m_under = 0, m_half = 0, m_hs = 0;
  int            m_pat = 0;

  function automatic logic [DW-1:0] trim(input logic [DW-1:0] w, input logic [1:0] c);
    if (c == 2'd0) return w & 32'h0000_00FF;
    if (c == 2'd1) return w & 32'h0000_FFFF;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_q.delete(); m_dout = '0; m_req = 0; m_under = 0;
      m_half = 0; m_hs = 0; m_pat = 0;
    end else begin
      int cnt;
      int nst;
      bit tk, do_pop, do_pat, nh, accept, lvl, open;
      cnt = m_q.size();
      nst = m_st; do_pop = 0; do_pat = 0; nh = m_hs;
      accept = wr_en && (cnt < DEP);
      tk = (cfg_rate == 2'd0) ? 1'b1 : (cfg_rate == 2'd1) ? m_half : timer_tick;
      lvl = (cnt > int'(cfg_ae_level));
      open = (cfg_gate == 2'd0) || (cfg_gate == 2'd1 && trig) ||
             (cfg_gate == 2'd2 && lvl) || (cfg_gate == 2'd3 && trig && lvl);
      if (stop) nst = 0;
      else if (m_st == 0) begin
        if (go) begin nst = 1; m_under = 0; end
      end else if (m_st == 1) begin
        if (open) nst = 2;
      end else begin
        if (cfg_mode == 2'd3 && cfg_trig_stop && !trig) nst = 0;
        else case (cfg_mode)
          2'd0: if (tk) begin if (cnt == 0) m_under = 1; else do_pop = 1; end
          2'd1: begin
            if (!m_hs && !ack) begin
              if (cnt == 0) m_under = 1; else begin do_pop = 1; nh = 1; end
            end else if (m_hs && ack) nh = 0;
          end
          2'd2: if (tk && ack) begin if (cnt == 0) m_under = 1; else do_pop = 1; end
          default: if (tk && cnt > 0) do_pat = 1;
        endcase
      end
      if (nst != 2) nh = 0;
      m_half = (m_st == 2) ? !m_half : 1'b0;
      if (do_pop) begin m_dout = trim(m_q[0], cfg_width); void'(m_q.pop_front()); end
      if (m_st != 2) m_pat = 0;
      else if (do_pat) begin
        m_dout = trim(m_q[m_pat], cfg_width);
        m_pat = (m_pat + 1 >= cnt) ? 0 : m_pat + 1;
      end
      case (cfg_mode)
        2'd1:    m_req = nh;
        2'd2:    m_req = (nst == 2);
        default: m_req = do_pop || do_pat;
      endcase
      m_hs = nh; m_st = nst;
      if (accept) m_q.push_back(wr_data);
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      chk(cur_req, "dout", dout, m_dout);
      chk(cur_req, "req", DW'(req), DW'(m_req));
      chk(cur_req, "fifo_empty", DW'(fifo_empty), DW'(m_q.size() == 0));
      chk(cur_req, "fifo_full", DW'(fifo_full), DW'(m_q.size() == DEP));
      chk(cur_req, "underrun", DW'(underrun), DW'(m_under));
    end
  end

  // Handshake responder: acknowledge follows request one cycle later.
  always @(negedge clk) if (hs_auto) ack = req;

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = base + DW'(i) * 32'h0103_0507;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] held;
    // R1: reset values
    cyc(3);
    chk("R1", "dout", dout, '0);
    chk("R1", "req", DW'(req), '0);
    chk("R1", "fifo_empty", DW'(fifo_empty), 32'd1);
    chk("R1", "fifo_full", DW'(fifo_full), '0);
    chk("R1", "underrun", DW'(underrun), '0);
    rst_n = 1'b1;
    cyc(2);

    // R12: fill past capacity, extra writes dropped
    cur_req = "R12";
    fill(DEP + 2, 32'hA1B2_C3D4);
    chk("R12", "fifo_full", DW'(fifo_full), 32'd1);

    // R3: paced, every cycle, drain and run dry
    cur_req = "R3";
    pulse_go();
    cyc(DEP + 4);
    chk("R6", "underrun after dry", DW'(underrun), 32'd1);
    pulse_stop();

    // R3: half rate, then timer pace
    cfg_rate = 2'd1;
    fill(4, 32'h1111_0000);
    pulse_go();
    cyc(12);
    pulse_stop();
    cfg_rate = 2'd2;
    fill(4, 32'h2222_0000);
    pulse_go();
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); timer_tick = (i % 3 == 1);
    end
    @(negedge clk); timer_tick = 1'b0;
    pulse_stop();

    // R9: narrow widths
    cur_req = "R9";
    cfg_rate = 2'd0;
    cfg_width = 2'd0;
    fill(3, 32'hDEAD_BEEF);
    pulse_go();
    cyc(5);
    pulse_stop();
    cfg_width = 2'd1;
    fill(3, 32'hCAFE_F00D);
    pulse_go();
    cyc(5);
    pulse_stop();
    cfg_width = 2'd2;

    // R2/R10: trigger gate with hold
    cur_req = "R10";
    cfg_gate = 2'd1;
    fill(3, 32'h3333_0001);
    pulse_go();
    held = dout;
    cyc(5);
    chk("R10", "dout held", dout, held);
    chk("R10", "req idle", DW'(req), '0);
    cur_req = "R2";
    @(negedge clk); trig = 1'b1;
    cyc(6);
    @(negedge clk); trig = 1'b0;
    pulse_stop();

    // R2: level gate, filled while armed then drained as written
    cfg_gate = 2'd2;
    cfg_ae_level = CW'(3);
    pulse_go();
    fill(2, 32'h4444_0000);
    cyc(3);
    fill(3, 32'h4545_0000);
    cyc(8);
    pulse_stop();

    // R2: both conditions
    cfg_gate = 2'd3;
    cfg_ae_level = CW'(1);
    fill(3, 32'h5555_0000);
    pulse_go();
    cyc(4);
    @(negedge clk); trig = 1'b1;
    cyc(6);
    @(negedge clk); trig = 1'b0;
    pulse_stop();
    cfg_gate = 2'd0;

    // R4: handshake, topped up as it runs dry
    cur_req = "R4";
    cfg_mode = 2'd1;
    hs_auto = 1;
    fill(3, 32'h6666_0000);
    pulse_go();
    cyc(12);
    fill(2, 32'h6767_0000);
    cyc(12);
    pulse_stop();
    hs_auto = 0;
    @(negedge clk); ack = 1'b0;

    // R5: burst at half rate with gapped acknowledge
    cur_req = "R5";
    cfg_mode = 2'd2;
    cfg_rate = 2'd1;
    fill(6, 32'h7777_0000);
    pulse_go();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); ack = (i % 3 != 0);
    end
    @(negedge clk); ack = 1'b0;
    pulse_stop();
    cfg_rate = 2'd0;

    // R7: pattern replay, no consumption, underrun cleared by go (R6)
    cur_req = "R7";
    cfg_mode = 2'd3;
    fill(3, 32'h8888_0000);
    pulse_go();
    cyc(15);
    chk("R7", "underrun in pattern", DW'(underrun), '0);
    chk("R7", "fifo_empty in pattern", DW'(fifo_empty), '0);
    pulse_stop();

    // R8: trigger release ends a pattern run
    cur_req = "R8";
    cfg_trig_stop = 1'b1;
    @(negedge clk); trig = 1'b1;
    pulse_go();
    cyc(6);
    @(negedge clk); trig = 1'b0;
    cyc(1);
    held = dout;
    cyc(4);
    chk("R8", "dout after release", dout, held);
    chk("R8", "req after release", DW'(req), '0);
    cfg_trig_stop = 1'b0;
    pulse_stop();

    // R11: stop wins over a pending tick
    cur_req = "R11";
    cfg_mode = 2'd0;
    cfg_rate = 2'd2;
    pulse_go();
    cyc(2);
    @(negedge clk); stop = 1'b1; timer_tick = 1'b1;
    @(negedge clk); stop = 1'b0; timer_tick = 1'b0;
    held = dout;
    cyc(3);
    chk("R11", "dout after stop", dout, held);
    chk("R11", "req after stop", DW'(req), '0);

    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule